// File: doc/BRIEF.md
# Disk arm seek controller

This block executes relative seek commands for one spindle of a two-surface disk drive that carries a removable and a fixed disk on a single access arm. A command arrives as a one-cycle strobe with a sector byte and a count byte. On a seek, bit 7 of the sector byte picks the read/write head, and bit 0 picks the direction. The arm cylinder then moves up or down by the count. A result below cylinder 0 is pinned at 0. A result past the last cylinder sends the arm back to 0 and raises an error.

Each disk on the spindle has its own cylinder register, but the arm is shared, so every accepted seek writes the same new value into both registers. After a seek the block holds a busy flag for a fixed settle time, counted in clock cycles. Seeks that arrive while it is busy are dropped. Any command clears the error flag when it starts. A reset, or a media-attach pulse, returns the arm to cylinder 0 and clears the busy and error indicators.

The controller has two states:
- ST_IDLE: waiting for a command.
- ST_SETTLE: the arm is settling.

There are three transitions:
- ST_IDLE to ST_SETTLE on an accepted seek.
- ST_SETTLE to ST_IDLE when the settle counter reaches zero.
- Any state to ST_IDLE on a media-attach pulse.

Top module: `arm_seek_ctrl`

## Requirements
- R1: After reset, and in the cycle after a `media_attach` pulse (even during a settle), both cylinder outputs are 0 and `head_sel`, `seek_busy` and `seek_err` are 0. `media_attach` takes priority over a command in the same cycle.
- R2: An accepted seek loads `head_sel` from bit 7 of `cmd_sector` (1 selects head 1, 0 selects head 0). Other sector bits do not affect the head.
- R3: An accepted seek with bit 0 of `cmd_sector` at 1 adds `cmd_count` to the cylinder. A result exactly equal to MAX_CYL (203) is kept and raises no error.
- R4: An accepted seek with bit 0 of `cmd_sector` at 0 subtracts `cmd_count` from the cylinder. A result below 0 becomes 0, and `seek_err` stays 0.
- R5: An upward result greater than MAX_CYL sets the cylinder to 0 and sets `seek_err`. The cylinder never exceeds MAX_CYL.
- R6: `cyl_removable` and `cyl_fixed` are always equal. A seek addressed to either unit (`cmd_unit` 0 = removable, 1 = fixed) moves both.
- R7: `seek_busy` rises in the cycle after an accepted seek and stays high for exactly SETTLE_CYCLES cycles (default 6).
- R8: A seek strobed while `seek_busy` is high is ignored. The cylinders, head, error and busy period are unchanged, both then and after the settle ends.
- R9: Any command strobe with `cmd_is_seek` at 0 clears `seek_err` in the next cycle, even while busy, and leaves cylinder and head unchanged. An accepted seek clears any earlier error before its own range check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| media_attach | input | 1 | One-cycle pulse: media loaded, home the arm |
| cmd_valid | input | 1 | Command strobe |
| cmd_is_seek | input | 1 | 1 = seek command, 0 = other command |
| cmd_unit | input | 1 | Addressed disk: 0 removable, 1 fixed |
| cmd_sector | input | 8 | Sector byte: bit 7 head, bit 0 direction |
| cmd_count | input | 8 | Cylinder distance |
| cyl_removable | output | 8 | Cylinder register of the removable disk |
| cyl_fixed | output | 8 | Cylinder register of the fixed disk |
| head_sel | output | 1 | Selected head |
| seek_busy | output | 1 | Arm settling |
| seek_err | output | 1 | Seek past last cylinder |

## Verification
The seek function is driven by a vector walk whose steps differ in several ways:
- direction bit;
- head bit;
- addressed unit;
- count (including 0, 255, and values landing exactly on 203 or one past it).

Exact landing on 203 versus one beyond it shows whether the range compare has an off-by-one error. Subtractions larger than the current cylinder show clamping apart from wrapping. Sector bytes with only the middle bits set, or only the middle bits clear, show that just bits 7 and 0 are decoded. Directed runs then strike a second seek, a plain command and a media-attach pulse in the middle of a settle. These show whether the busy gate, the error clear and the attach priority each act on their own.

// File: rtl/arm_seek_pkg.sv
package arm_seek_pkg;

    localparam int HEAD_BIT  = 7;
    localparam int DIR_BIT   = 0;
    localparam int NUM_UNITS = 2;   // removable + fixed on one spindle

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SETTLE = 1'b1
    } arm_state_e;

endpackage

// File: rtl/arm_seek_alu.sv
module arm_seek_alu #(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 203
) (
    input  logic [CYL_W-1:0] cur_cyl,
    input  logic [CYL_W-1:0] distance,
    input  logic             move_up,
    output logic [CYL_W-1:0] nxt_cyl,
    output logic             overrange
);
    localparam int SUM_W = CYL_W + 1;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(MAX_CYL);

    logic [SUM_W-1:0] sum_up;

    always_comb begin
        sum_up    = {1'b0, cur_cyl} + {1'b0, distance};
        overrange = 1'b0;
        if (move_up) begin
            if (sum_up > LIMIT) begin
                overrange = 1'b1;
                nxt_cyl   = '0;
            end else begin
                nxt_cyl = sum_up[CYL_W-1:0];
            end
        end else if (distance > cur_cyl) begin
            nxt_cyl = '0;   // below track 0: pin at home, no error
        end else begin
            nxt_cyl = cur_cyl - distance;
        end
    end

    // R5: a flagged result is always the home cylinder
    always_comb begin
        if (overrange) a_r5_wrap_home: assert (nxt_cyl == '0);
    end
endmodule

// File: rtl/arm_settle_timer.sv
module arm_settle_timer #(
    parameter int SETTLE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R7: a load always starts the full window
    a_r7_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> (cnt_q == LOAD));
    a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);
endmodule

// File: rtl/arm_seek_ctrl.sv
module arm_seek_ctrl #(
    parameter int CYL_W         = 8,
    parameter int MAX_CYL       = 203,
    parameter int SETTLE_CYCLES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             media_attach,
    input  logic             cmd_valid,
    input  logic             cmd_is_seek,
    input  logic             cmd_unit,
    input  logic [7:0]       cmd_sector,
    input  logic [7:0]       cmd_count,
    output logic [CYL_W-1:0] cyl_removable,
    output logic [CYL_W-1:0] cyl_fixed,
    output logic             head_sel,
    output logic             seek_busy,
    output logic             seek_err
);
    import arm_seek_pkg::*;

    arm_state_e       state_q, state_d;
    logic [CYL_W-1:0] cyl_q [NUM_UNITS];
    logic [CYL_W-1:0] sel_cyl, alu_cyl;
    logic             alu_over, head_q, err_q;
    logic             accept_seek, plain_cmd, settle_done;

    assign accept_seek = cmd_valid && cmd_is_seek && !media_attach && (state_q == ST_IDLE);
    assign plain_cmd   = cmd_valid && !cmd_is_seek && !media_attach;
    assign sel_cyl     = cyl_q[cmd_unit];

    arm_seek_alu #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_alu (
        .cur_cyl  (sel_cyl),
        .distance (CYL_W'(cmd_count)),
        .move_up  (cmd_sector[DIR_BIT]),
        .nxt_cyl  (alu_cyl),
        .overrange(alu_over)
    );

    arm_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (media_attach),
        .start  (accept_seek),
        .expired(settle_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept_seek) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (media_attach) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers: head and error
    always_ff @(posedge clk) begin
        if (!rst_n || media_attach) begin
            head_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (accept_seek) begin
            head_q <= cmd_sector[HEAD_BIT];
            err_q  <= alu_over;
        end else if (plain_cmd) begin
            err_q  <= 1'b0;
        end
    end

    // one cylinder register per disk, all driven by the shared arm
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        always_ff @(posedge clk) begin
            if (!rst_n || media_attach) cyl_q[u] <= '0;
            else if (accept_seek)       cyl_q[u] <= alu_cyl;
        end
    end

    assign cyl_removable = cyl_q[0];
    assign cyl_fixed     = cyl_q[1];
    assign head_sel      = head_q;
    assign seek_err      = err_q;
    assign seek_busy     = (state_q == ST_SETTLE);

    // R1: attach homes the arm
    a_r1_attach_home: assert property (@(posedge clk) disable iff (!rst_n)
        media_attach |=> (cyl_removable == '0 && !seek_busy && !seek_err && !head_sel));
    // R5: cylinder never beyond the last one
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cyl_removable <= CYL_W'(MAX_CYL));
    // R6: shared arm keeps both disks on one cylinder
    a_r6_arms_equal: assert property (@(posedge clk) disable iff (!rst_n)
        cyl_removable == cyl_fixed);
    // R7: an accepted seek raises busy
    a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_seek && !seek_busy && !media_attach) |=> seek_busy);
    // R8: seeks while busy leave the arm alone
    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (seek_busy && !media_attach) |=> ($stable(cyl_removable) && $stable(head_sel)));
    // R9: a plain command clears the error
    a_r9_plain_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_is_seek) |=> !seek_err);
endmodule

// File: tb/arm_seek_ctrl_tb.sv
module arm_seek_ctrl_tb;
    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       media_attach = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_is_seek = 1'b0;
    logic       cmd_unit = 1'b0;
    logic [7:0] cmd_sector = '0;
    logic [7:0] cmd_count = '0;
    logic [7:0] cyl_removable, cyl_fixed;
    logic       head_sel, seek_busy, seek_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    arm_seek_ctrl #(.CYL_W(8), .MAX_CYL(203), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .media_attach(media_attach),
        .cmd_valid(cmd_valid), .cmd_is_seek(cmd_is_seek), .cmd_unit(cmd_unit),
        .cmd_sector(cmd_sector), .cmd_count(cmd_count),
        .cyl_removable(cyl_removable), .cyl_fixed(cyl_fixed),
        .head_sel(head_sel), .seek_busy(seek_busy), .seek_err(seek_err)
    );

    // vector: sector[26:19] count[18:11] unit[10] cyl[9:2] head[1] err[0]
    localparam logic [26:0] VEC [11] = '{
        {8'h01, 8'd10,  1'b0, 8'd10,  1'b0, 1'b0},  // R3 up
        {8'h81, 8'd50,  1'b1, 8'd60,  1'b1, 1'b0},  // R2 R6 head 1, fixed unit
        {8'h00, 8'd20,  1'b0, 8'd40,  1'b0, 1'b0},  // R4 down
        {8'h80, 8'd100, 1'b1, 8'd0,   1'b1, 1'b0},  // R4 clamp below 0
        {8'h01, 8'd203, 1'b0, 8'd203, 1'b0, 1'b0},  // R3 exactly last cylinder
        {8'h01, 8'd1,   1'b1, 8'd0,   1'b0, 1'b1},  // R5 one past end
        {8'h00, 8'd0,   1'b0, 8'd0,   1'b0, 1'b0},  // R9 seek clears error
        {8'h01, 8'd255, 1'b0, 8'd0,   1'b0, 1'b1},  // R5 max count
        {8'h01, 8'd100, 1'b1, 8'd100, 1'b0, 1'b0},  // R3 R9
        {8'h7F, 8'd3,   1'b0, 8'd103, 1'b0, 1'b0},  // R2 middle bits ignored
        {8'hFE, 8'd3,   1'b1, 8'd100, 1'b1, 1'b0}   // R2 R4 middle bits ignored
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic seek, input logic unit,
                          input logic [7:0] sec, input logic [7:0] cnt);
        cmd_valid   = 1'b1;
        cmd_is_seek = seek;
        cmd_unit    = unit;
        cmd_sector  = sec;
        cmd_count   = cnt;
        @(negedge clk);
        cmd_valid   = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (seek_busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (seek_busy) chk("R7 busy never cleared", 1, 0);
    endtask

    task automatic check_arm(input string req, input int cyl, input int head, input int err);
        chk({req, " cyl_removable"}, cyl_removable, cyl);
        chk({req, " cyl_fixed"}, cyl_fixed, cyl);
        chk({req, " head"}, head_sel, head);
        chk({req, " err"}, seek_err, err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_arm("R1 reset", 0, 0, 0);
        chk("R1 reset busy", seek_busy, 0);

        // vector walk
        for (int i = 0; i < 11; i++) begin
            logic [26:0] v;
            v = VEC[i];
            wait_idle();
            strobe(1'b1, v[10], v[26:19], v[18:11]);
            check_arm($sformatf("R2-vec%0d R3 R4 R5 R6", i), v[9:2], v[1], v[0]);
        end
        wait_idle();

        // R7: exact busy length
        begin
            int busy_n = 0;
            strobe(1'b1, 1'b0, 8'h01, 8'd5);   // 100 -> 105
            while (seek_busy && busy_n < 100) begin
                busy_n++;
                @(negedge clk);
            end
            chk("R7 busy cycles", busy_n, SETTLE);
        end

        // R8: seek during busy ignored
        strobe(1'b1, 1'b1, 8'h00, 8'd5);       // 105 -> 100, head 0
        @(negedge clk);
        strobe(1'b1, 1'b0, 8'h81, 8'd50);      // ignored
        check_arm("R8 ignored during busy", 100, 0, 0);
        chk("R8 still busy", seek_busy, 1);
        wait_idle();
        check_arm("R8 no deferred seek", 100, 0, 0);

        // R9: plain command clears error, leaves arm
        strobe(1'b1, 1'b0, 8'h81, 8'd200);     // overrange -> 0, err, head 1
        check_arm("R5 overrange", 0, 1, 1);
        strobe(1'b0, 1'b0, 8'h00, 8'd9);       // plain command while busy
        check_arm("R9 plain clears error", 0, 1, 0);
        wait_idle();

        // R1: attach mid-settle, and priority over a seek in the same cycle
        strobe(1'b1, 1'b1, 8'h81, 8'd77);
        check_arm("R6 seek on fixed", 77, 1, 0);
        @(negedge clk);
        media_attach = 1'b1;
        strobe(1'b1, 1'b0, 8'h01, 8'd40);
        media_attach = 1'b0;
        check_arm("R1 attach", 0, 0, 0);
        chk("R1 attach busy", seek_busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule